// File: doc/BRIEF.md
# Self-Timed Nonvolatile Memory Control Register

This block is an 8-bit control and status register on a processor register bus. It sequences accesses to an on-chip nonvolatile store: data EEPROM, program flash or configuration space. Software picks the target space with two select bits and arms a write enable. It can also request a row erase. It then starts a read or a self-timed erase/write by setting a start bit. Software can only set the start bits, and the hardware clears them.

On each accepted start the block sends a one-cycle strobe to a memory back end. For a write it also sends whether the operation is an erase or a program. It waits for a one-cycle completion input from the back end. A warm reset that arrives while a write is still running latches an error flag. The select bits are kept, so the failed target can still be traced. An attempt to start a write without the enable is refused and also raises the error flag.

Top module: `nvm_ctrl_reg`

## Requirements
- R1: The register image is, from bit 7 down to bit 0: flash select, configuration select, a reserved bit that always reads 0, erase enable, error flag, write enable, write busy/start, read start.
- R2: While `rst_n` is low at a clock edge, every bit of the register is cleared to 0, and both strobes are 0.
- R3: A bus write with bit 1 set, while the write enable already holds 1 and no write is busy, sets bit 1 and raises `wr_start_o` for exactly one cycle. During that cycle `erase_op_o` equals the erase enable. Writing 0 to bit 1 never clears it.
- R4: While bit 1 is set, a `be_done_i` pulse clears bit 1, the erase enable and the error flag at the next edge.
- R5: A bus write with bit 1 set while the write enable holds 0 leaves bit 1 at 0, gives no strobe, and sets the error flag.
- R6: An accepted read request shows bit 0 and `rd_start_o` high for exactly one cycle, and both then return to 0.
- R7: A read request is refused when the flash select or the configuration select is 1. The select values used are those that result from the same bus write.
- R8: While a write is busy, bus writes do not change the select bits or the erase enable.
- R9: A `warm_rst` pulse while a write is busy clears bit 1 and sets the error flag, and it keeps both select bits. In every case `warm_rst` clears the write enable, the erase enable and bit 0. When no write is busy it leaves the error flag unchanged.
- R10: When no write is busy, software can write either value to the select bits, the erase enable, the error flag and the write enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| warm_rst | input | 1 | Warm reset; aborts a write in progress |
| reg_we | input | 1 | Bus write strobe for this register |
| reg_wdata | input | 8 | Bus write data |
| reg_rdata | output | 8 | Current register image |
| sel_flash_o | output | 1 | Flash space selected |
| sel_cfg_o | output | 1 | Configuration space selected |
| erase_op_o | output | 1 | Started write is a row erase (valid with `wr_start_o`) |
| wr_start_o | output | 1 | One-cycle erase/write start strobe |
| rd_start_o | output | 1 | One-cycle read start strobe |
| be_done_i | input | 1 | One-cycle completion from the back end |

## Verification
The bench drives the block with a behavioural back end whose write latency is a bench parameter, set to 6 cycles. That latency keeps the busy window open long enough to drive bus writes into the middle of a write: attempts to clear the busy bit, changes to the select bits, and a warm reset that arrives before completion. A reference model compares the whole register image and both strobes on every clock.

// File: rtl/nvm_pkg.sv
// Package: shared bit positions and types for the nonvolatile memory
// control register. Positions are fixed because software decodes them.
package nvm_pkg;
    localparam int unsigned REG_W   = 8;
    localparam int unsigned B_FLASH = 7;
    localparam int unsigned B_CFG   = 6;
    localparam int unsigned B_RSVD  = 5;
    localparam int unsigned B_ERASE = 4;
    localparam int unsigned B_ERR   = 3;
    localparam int unsigned B_WREN  = 2;
    localparam int unsigned B_WR    = 1;
    localparam int unsigned B_RD    = 0;

    typedef struct packed {
        logic flash;
        logic cfg;
    } nvm_sel_t;
endpackage

// File: rtl/nvm_sel_reg.sv
// Module: target-select bits.
// Holds the flash and configuration selects. Bus writes are taken only
// when no write is busy and no warm reset is present. Also outputs the
// value these bits will hold after the current edge, for the read gate.
module nvm_sel_reg
    import nvm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     warm_rst,
    input  logic     sw_we,
    input  logic     busy,
    input  nvm_sel_t sw_sel,
    output nvm_sel_t sel_q,
    output nvm_sel_t sel_nxt
);
    // Next select value: a bus write applies only when the block is idle.
    always_comb begin
        sel_nxt = (sw_we && !busy && !warm_rst) ? sw_sel : sel_q;
    end

    // Select state register.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_nxt;
    end
endmodule

// File: rtl/nvm_wr_seq.sv
// Module: erase/write sequencer.
// Owns the erase enable, error flag, write enable and busy bit. It
// assumes be_done_i is a single-cycle pulse from the back end.
module nvm_wr_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic warm_rst,
    input  logic sw_we,
    input  logic sw_erase,
    input  logic sw_err,
    input  logic sw_wren,
    input  logic sw_wr,
    input  logic be_done_i,
    output logic erase_q,
    output logic err_q,
    output logic wren_q,
    output logic wr_q,
    output logic wr_strobe
);
    logic start_ok;
    logic start_bad;

    // Classify a start request against the enable that is already stored.
    always_comb begin
        start_ok  = sw_we && sw_wr && !wr_q && wren_q;
        start_bad = sw_we && sw_wr && !wr_q && !wren_q;
    end

    // Sequencer state: warm reset, then bus write, then completion wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erase_q   <= 1'b0;
            err_q     <= 1'b0;
            wren_q    <= 1'b0;
            wr_q      <= 1'b0;
            wr_strobe <= 1'b0;
        end else if (warm_rst) begin
            err_q     <= err_q | wr_q;
            erase_q   <= 1'b0;
            wren_q    <= 1'b0;
            wr_q      <= 1'b0;
            wr_strobe <= 1'b0;
        end else begin
            wr_strobe <= start_ok;
            if (sw_we) begin
                wren_q <= sw_wren;
                err_q  <= sw_err | start_bad;
                if (!wr_q) erase_q <= sw_erase;
            end
            if (start_ok) wr_q <= 1'b1;
            if (wr_q && be_done_i) begin
                wr_q    <= 1'b0;
                erase_q <= 1'b0;
                err_q   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/nvm_rd_seq.sv
// Module: read sequencer.
// Sets the read bit for one cycle on an accepted request. A request is
// refused while the resulting selects point at flash or configuration
// space, or while the bit is already set.
module nvm_rd_seq
    import nvm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     warm_rst,
    input  logic     sw_we,
    input  logic     sw_rd,
    input  nvm_sel_t sel_nxt,
    output logic     rd_q
);
    logic accept;

    // Read gate: only the data EEPROM space may be read through this bit.
    always_comb begin
        accept = sw_we && sw_rd && !rd_q && !sel_nxt.flash && !sel_nxt.cfg;
    end

    // Read bit: set on accept, cleared by hardware one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n)        rd_q <= 1'b0;
        else if (warm_rst) rd_q <= 1'b0;
        else               rd_q <= accept;
    end
endmodule

// File: rtl/nvm_ctrl_reg.sv
// Module: self-timed nonvolatile memory control register (top).
// Splits bus writes into fields, builds the read image and drives the
// back-end strobes. Assumes a single register-bus master and a
// synchronous warm reset input.
module nvm_ctrl_reg
    import nvm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             warm_rst,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             sel_flash_o,
    output logic             sel_cfg_o,
    output logic             erase_op_o,
    output logic             wr_start_o,
    output logic             rd_start_o,
    input  logic             be_done_i
);
    nvm_sel_t sw_sel, sel_q, sel_nxt;
    logic     erase_q, err_q, wren_q, wr_q, wr_strobe, rd_q;
    logic     unused_rsvd;

    // Field split of the bus write data.
    always_comb begin
        sw_sel.flash = reg_wdata[B_FLASH];
        sw_sel.cfg   = reg_wdata[B_CFG];
    end
    assign unused_rsvd = reg_wdata[B_RSVD];

    nvm_sel_reg u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .warm_rst(warm_rst),
        .sw_we   (reg_we),
        .busy    (wr_q),
        .sw_sel  (sw_sel),
        .sel_q   (sel_q),
        .sel_nxt (sel_nxt)
    );

    nvm_wr_seq u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .warm_rst (warm_rst),
        .sw_we    (reg_we),
        .sw_erase (reg_wdata[B_ERASE]),
        .sw_err   (reg_wdata[B_ERR]),
        .sw_wren  (reg_wdata[B_WREN]),
        .sw_wr    (reg_wdata[B_WR]),
        .be_done_i(be_done_i),
        .erase_q  (erase_q),
        .err_q    (err_q),
        .wren_q   (wren_q),
        .wr_q     (wr_q),
        .wr_strobe(wr_strobe)
    );

    nvm_rd_seq u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .warm_rst(warm_rst),
        .sw_we   (reg_we),
        .sw_rd   (reg_wdata[B_RD]),
        .sel_nxt (sel_nxt),
        .rd_q    (rd_q)
    );

    // Read image assembly; the reserved bit is tied low.
    always_comb begin
        reg_rdata          = '0;
        reg_rdata[B_FLASH] = sel_q.flash;
        reg_rdata[B_CFG]   = sel_q.cfg;
        reg_rdata[B_ERASE] = erase_q;
        reg_rdata[B_ERR]   = err_q;
        reg_rdata[B_WREN]  = wren_q;
        reg_rdata[B_WR]    = wr_q;
        reg_rdata[B_RD]    = rd_q;
    end

    // Back-end side outputs.
    assign sel_flash_o = sel_q.flash;
    assign sel_cfg_o   = sel_q.cfg;
    assign erase_op_o  = erase_q;
    assign wr_start_o  = wr_strobe;
    assign rd_start_o  = rd_q;
endmodule

// File: rtl/nvm_ctrl_reg_chk.sv
// Module: assertion checker for nvm_ctrl_reg, attached with bind.
module nvm_ctrl_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       warm_rst,
    input logic       reg_we,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       sel_flash_o,
    input logic       sel_cfg_o,
    input logic       wr_start_o,
    input logic       rd_start_o,
    input logic       be_done_i
);
    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[5] == 1'b0);

    p_wr_strobe_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start_o |=> !wr_start_o);

    p_wr_strobe_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start_o |-> reg_rdata[1]);

    p_done_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[1] && be_done_i && !warm_rst) |=>
            (!reg_rdata[1] && !reg_rdata[3] && !reg_rdata[4]));

    p_bad_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_wdata[1] && !reg_rdata[2] && !reg_rdata[1] && !warm_rst) |=>
            (reg_rdata[3] && !reg_rdata[1]));

    p_rd_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start_o |=> !reg_rdata[0]);

    p_rd_space_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start_o |-> (!sel_flash_o && !sel_cfg_o));

    p_sel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[1] && !warm_rst) |=> $stable(reg_rdata[7:6]));

    p_warm_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_rst && reg_rdata[1]) |=> (reg_rdata[3] && !reg_rdata[1]));
endmodule

bind nvm_ctrl_reg nvm_ctrl_reg_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .warm_rst   (warm_rst),
    .reg_we     (reg_we),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .sel_flash_o(sel_flash_o),
    .sel_cfg_o  (sel_cfg_o),
    .wr_start_o (wr_start_o),
    .rd_start_o (rd_start_o),
    .be_done_i  (be_done_i)
);

// File: tb/nvm_ctrl_reg_tb.sv
`timescale 1ns/1ps
module nvm_ctrl_reg_tb;
    localparam int WR_LAT = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       warm_rst = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sel_flash_o, sel_cfg_o, erase_op_o, wr_start_o, rd_start_o;
    logic       be_done = 1'b0;

    int tests = 0;
    int fails = 0;
    int be_cnt = 0;
    bit ops_q[$];

    // reference model state
    bit m_flash, m_cfg, m_erase, m_err, m_wren, m_wr, m_rd, m_wrstb;

    always #2 clk = ~clk;

    nvm_ctrl_reg u_dut (
        .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sel_flash_o(sel_flash_o), .sel_cfg_o(sel_cfg_o),
        .erase_op_o(erase_op_o), .wr_start_o(wr_start_o),
        .rd_start_o(rd_start_o), .be_done_i(be_done)
    );

    // behavioural back end with programmable write latency
    always @(posedge clk) begin
        be_done <= 1'b0;
        if (!rst_n || warm_rst) be_cnt <= 0;
        else if (wr_start_o) begin
            be_cnt <= WR_LAT;
            ops_q.push_back(erase_op_o);
        end else if (be_cnt > 1) be_cnt <= be_cnt - 1;
        else if (be_cnt == 1) begin
            be_cnt  <= 0;
            be_done <= 1'b1;
        end
    end

    // cycle-by-cycle reference model
    always @(posedge clk) begin
        bit busy, wen_old, rd_old;
        busy = m_wr; wen_old = m_wren; rd_old = m_rd;
        m_wrstb = 0;
        if (!rst_n) begin
            {m_flash, m_cfg, m_erase, m_err, m_wren, m_wr, m_rd} = '0;
        end else if (warm_rst) begin
            if (busy) m_err = 1;
            m_wr = 0; m_wren = 0; m_erase = 0; m_rd = 0;
        end else begin
            m_rd = 0;
            if (reg_we) begin
                if (!busy) begin
                    m_flash = reg_wdata[7]; m_cfg = reg_wdata[6]; m_erase = reg_wdata[4];
                end
                m_err = reg_wdata[3]; m_wren = reg_wdata[2];
                if (reg_wdata[1] && !busy) begin
                    if (wen_old) begin m_wr = 1; m_wrstb = 1; end
                    else m_err = 1;
                end
                if (reg_wdata[0] && !rd_old && !m_flash && !m_cfg) m_rd = 1;
            end
            if (busy && be_done) begin m_wr = 0; m_erase = 0; m_err = 0; end
        end
    end

    function automatic logic [7:0] model_img();
        return {m_flash, m_cfg, 1'b0, m_erase, m_err, m_wren, m_wr, m_rd};
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            tests += 3;
            if (reg_rdata !== model_img()) begin
                fails++;
                $display("FAIL R1 image: actual %02h expected %02h", reg_rdata, model_img());
            end
            if (wr_start_o !== m_wrstb) begin
                fails++;
                $display("FAIL R3 write strobe: actual %0b expected %0b", wr_start_o, m_wrstb);
            end
            if (rd_start_o !== m_rd) begin
                fails++;
                $display("FAIL R6 read strobe: actual %0b expected %0b", rd_start_o, m_rd);
            end
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [7:0] d);
        @(negedge clk); reg_we = 1'b1; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic pulse_warm();
        @(negedge clk); warm_rst = 1'b1;
        @(negedge clk); warm_rst = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 50; i++) begin
            if (!reg_rdata[1]) break;
            @(negedge clk);
        end
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R2 reset image", reg_rdata, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 after release", reg_rdata, 8'h00);

        bus_wr(8'hC4); chk("R10 idle write", reg_rdata, 8'hC4);
        bus_wr(8'h18); chk("R10 idle write 2", reg_rdata, 8'h18);
        bus_wr(8'h20); chk("R1 reserved bit", reg_rdata, 8'h00);

        bus_wr(8'h02); chk("R5 refused start", reg_rdata, 8'h08);
        chk("R5 no strobe", {7'd0, wr_start_o}, 8'h00);

        bus_wr(8'h04);
        bus_wr(8'h06);
        chk("R3 busy set", reg_rdata, 8'h06);
        chk("R3 strobe", {7'd0, wr_start_o}, 8'h01);
        bus_wr(8'h04); chk("R3 no sw clear", reg_rdata, 8'h06);
        bus_wr(8'hD4); chk("R8 busy ignores selects", reg_rdata, 8'h04 | 8'h02);
        wait_idle();
        chk("R4 done clears", reg_rdata, 8'h04);

        bus_wr(8'h14); chk("R10 erase enable", reg_rdata, 8'h14);
        bus_wr(8'h1E);
        chk("R3 erase op", {7'd0, erase_op_o}, 8'h01);
        wait_idle();
        chk("R4 erase cleared", reg_rdata, 8'h04);
        chk("R3 op log", {6'd0, 1'(ops_q.size() == 2), ops_q.size() == 2 ? 1'(ops_q[1]) : 1'b0}, 8'h03);

        bus_wr(8'h01);
        chk("R6 read bit set", reg_rdata, 8'h01);
        chk("R6 read strobe", {7'd0, rd_start_o}, 8'h01);
        @(negedge clk);
        chk("R6 read bit cleared", reg_rdata, 8'h00);

        bus_wr(8'h81); chk("R7 flash refuses read", reg_rdata, 8'h80);
        bus_wr(8'h41); chk("R7 cfg refuses read", reg_rdata, 8'h40);
        bus_wr(8'h01); chk("R7 new select used", reg_rdata, 8'h01);

        bus_wr(8'h84);
        bus_wr(8'h86);
        repeat (2) @(negedge clk);
        pulse_warm();
        chk("R9 abort keeps select", reg_rdata, 8'h88);
        repeat (WR_LAT + 2) @(negedge clk);
        chk("R9 no late completion", reg_rdata, 8'h88);

        bus_wr(8'h54); pulse_warm();
        chk("R9 idle warm", reg_rdata, 8'h40);
        bus_wr(8'h08); pulse_warm();
        chk("R9 idle warm keeps err", reg_rdata, 8'h08);

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule